// File: doc/BRIEF.md
# 1-Wire Bit Cycle Timing Engine

This block produces single timed cycles on a 1-wire line at the physical layer. Each cycle is a reset with presence detection, a write-0 slot, a write-1/read slot, or a timed idle. Each can run at normal speed or at overdrive speed. A one-clock start strobe launches the cycle. Three configuration bits go with the strobe: a speed bit, a reset-type bit and a data bit. Together they pick the cycle. The block drives an open-drain pull-down enable and samples the line through a two-flop synchronizer. It reports busy status, a one-clock done pulse and the bit it sampled.

A prescaler turns the system clock into a base tick. There is one divider ratio for normal speed and one for overdrive, and the speed bit of the running cycle selects between them. A single down-counter, loaded at the start and stepped once per tick, fixes every phase of the cycle: how long the line is driven low, where the sample is taken and where the cycle ends. Byte handling, line selection, strong pull-up and any register access belong to the logic around this block.

Top module: `onewire_slot_engine`

## Requirements
- R1: After reset, busy_o, done_o and line_pull_o are 0, and bit_o is 1.
- R2: A base tick occurs every (ratio+1) system clocks, counted from the start strobe. The ratio used is ratio_norm_i when the cycle was started with ovd_i=0 and ratio_ovd_i when ovd_i=1, so any phase of P ticks lasts P*(ratio+1) clocks.
- R3: A normal reset cycle (ovd_i=0, reset_req_i=1, dat_i=0) lasts 128 ticks. The line is pulled low for the first 64 ticks, and the line is sampled at tick 74. The sampled value becomes bit_o, so 0 means a device answered.
- R4: A normal write-0 slot (ovd_i=0, reset_req_i=0, dat_i=0) lasts 9 ticks, with the line pulled low for the first 8.
- R5: A normal write-1/read slot (ovd_i=0, reset_req_i=0, dat_i=1) lasts 9 ticks. The line is pulled low for the first tick and sampled at tick 2.
- R6: An overdrive reset cycle (ovd_i=1, reset_req_i=1, dat_i=0) lasts 96 ticks. The line is pulled low for the first 48 ticks and sampled at tick 58.
- R7: Overdrive slots last 8 ticks. A write-0 (dat_i=0) pulls the line low for 6 ticks. A write-1/read (dat_i=1) pulls it low for 1 tick and samples at tick 2.
- R8: An idle cycle (reset_req_i=1, dat_i=1) never pulls the line. At normal speed it keeps busy_o high for 128 ticks. At overdrive speed busy_o stays 0 and done_o pulses in the clock after the strobe.
- R9: bit_o changes only when a cycle ends, and then takes the value held by the internal sample register. An idle cycle takes no sample, so bit_o keeps its previous value.
- R10: A start strobe during a running cycle abandons that cycle without a done pulse and starts the new one from its beginning.
- R11: busy_o is high from the clock after the strobe until the last tick, and done_o is high for exactly the one clock after the last tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock request to begin a cycle |
| ovd_i | input | 1 | Speed of the requested cycle: 1 is overdrive |
| reset_req_i | input | 1 | Cycle type: 1 selects reset, or idle when dat_i=1 |
| dat_i | input | 1 | Data bit of the slot, or idle select with reset_req_i |
| ratio_norm_i | input | DIV_W | Divider ratio for normal speed |
| ratio_ovd_i | input | DIV_W | Divider ratio for overdrive speed |
| line_i | input | 1 | Level on the 1-wire line, asynchronous |
| line_pull_o | output | 1 | Open-drain enable: 1 pulls the line low |
| busy_o | output | 1 | A cycle is running |
| done_o | output | 1 | One-clock pulse when a cycle finishes |
| bit_o | output | 1 | Sampled bit of the last finished cycle |

## Verification
The prescaler bound check assumes both ratios stay constant while a cycle runs. The stimulus programs them only while the engine is idle. The sample-point check also assumes a ratio of at least 2, so that a released line has passed the synchronizer before it is sampled. The bench uses ratios from 2 to 5. A device is modelled as holding the line low through the whole cycle or not at all, so the expected bit does not depend on where inside a window the sample lands. The start strobe is the only input that may change while a cycle runs; the abort test depends on it.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int TW = 8;
  typedef logic [TW-1:0] tcnt_t;

  typedef struct packed {
    tcnt_t len;
    tcnt_t low;
    tcnt_t samp;
    logic  samp_en;
    logic  idle;
  } shape_t;

  function automatic shape_t cycle_shape(input logic ovd, input logic rs, input logic dat);
    shape_t s;
    s = '{len: '0, low: '0, samp: '0, samp_en: 1'b0, idle: 1'b0};
    unique case ({ovd, rs, dat})
      3'b000: s = '{len: 8'd9,   low: 8'd8,  samp: 8'd2,  samp_en: 1'b1, idle: 1'b0};
      3'b001: s = '{len: 8'd9,   low: 8'd1,  samp: 8'd2,  samp_en: 1'b1, idle: 1'b0};
      3'b010: s = '{len: 8'd128, low: 8'd64, samp: 8'd74, samp_en: 1'b1, idle: 1'b0};
      3'b011: s = '{len: 8'd128, low: 8'd0,  samp: 8'd0,  samp_en: 1'b0, idle: 1'b1};
      3'b100: s = '{len: 8'd8,   low: 8'd6,  samp: 8'd2,  samp_en: 1'b1, idle: 1'b0};
      3'b101: s = '{len: 8'd8,   low: 8'd1,  samp: 8'd2,  samp_en: 1'b1, idle: 1'b0};
      3'b110: s = '{len: 8'd96,  low: 8'd48, samp: 8'd58, samp_en: 1'b1, idle: 1'b0};
      default: s = '{len: 8'd0,  low: 8'd0,  samp: 8'd0,  samp_en: 1'b0, idle: 1'b1};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/owt_sync.sv
module owt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/owt_tick.sv
module owt_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || restart_i)  pcnt <= '0;
    else if (run_i) begin
      if (pcnt == ratio_i) pcnt <= '0;
      else                 pcnt <= pcnt + 1'b1;
    end
  end

  assign tick_o = run_i && (pcnt == ratio_i);

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_i |-> pcnt <= ratio_i); // R2
endmodule

// File: rtl/owt_seq.sv
module owt_seq
  import owt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   ovd_i,
  input  shape_t shape_i,
  input  logic   tick_i,
  input  logic   line_s_i,
  output logic   mode_ovd_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   pull_o,
  output logic   bit_o
);
  tcnt_t cnt, cnt_nx, low_thr, samp_rem;
  logic  samp_en, idle_q, samp_q;

  assign cnt_nx = cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      low_thr    <= '0;
      samp_rem   <= '0;
      samp_en    <= 1'b0;
      idle_q     <= 1'b0;
      samp_q     <= 1'b1;
      mode_ovd_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      pull_o     <= 1'b0;
      bit_o      <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        mode_ovd_o <= ovd_i;
        low_thr    <= shape_i.len - shape_i.low;
        samp_rem   <= shape_i.len - shape_i.samp;
        samp_en    <= shape_i.samp_en;
        idle_q     <= shape_i.idle;
        cnt        <= shape_i.len;
        if (shape_i.len == '0) begin
          busy_o <= 1'b0;
          pull_o <= 1'b0;
          done_o <= 1'b1;
          bit_o  <= samp_q;
        end else begin
          busy_o <= 1'b1;
          pull_o <= (shape_i.low != '0);
        end
      end else if (busy_o && tick_i) begin
        cnt    <= cnt_nx;
        pull_o <= (cnt_nx > low_thr) && (cnt_nx != '0);
        if (samp_en && cnt_nx == samp_rem) samp_q <= line_s_i;
        if (cnt_nx == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          bit_o  <= samp_q;
        end
      end
    end
  end

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> cnt != '0); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !pull_o); // R8
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(bit_o)); // R9
endmodule

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine
  import owt_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ovd_i,
  input  logic             reset_req_i,
  input  logic             dat_i,
  input  logic [DIV_W-1:0] ratio_norm_i,
  input  logic [DIV_W-1:0] ratio_ovd_i,
  input  logic             line_i,
  output logic             line_pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             bit_o
);
  shape_t           shape;
  logic             line_s, tick, mode_ovd;
  logic [DIV_W-1:0] ratio_sel;

  assign shape     = cycle_shape(ovd_i, reset_req_i, dat_i);
  assign ratio_sel = mode_ovd ? ratio_ovd_i : ratio_norm_i;

  owt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_i(line_i), .q_o(line_s)
  );

  owt_tick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .restart_i(start_i), .run_i(busy_o),
    .ratio_i(ratio_sel), .tick_o(tick)
  );

  owt_seq i_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ovd_i(ovd_i), .shape_i(shape),
    .tick_i(tick), .line_s_i(line_s), .mode_ovd_o(mode_ovd),
    .busy_o(busy_o), .done_o(done_o), .pull_o(line_pull_o), .bit_o(bit_o)
  );

  AST_PULL_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    line_pull_o |-> busy_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R11
  AST_END_SIGNALLED: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o); // R10
endmodule

// File: tb/test_onewire_slot_engine.sv
module test_onewire_slot_engine;
  localparam int DIV_W = 16;

  typedef struct {
    int    busy_clk;
    int    low_clk;
    logic  b;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, ovd_i = 1'b0, reset_req_i = 1'b0, dat_i = 1'b0;
  logic [DIV_W-1:0] ratio_norm_i = 16'd3, ratio_ovd_i = 16'd2;
  logic slave_hold = 1'b0;
  logic line_i, line_pull_o, busy_o, done_o, bit_o;

  int checks = 0, fails = 0, pushed = 0, popped = 0;
  int cnt_busy = 0, cnt_low = 0;
  logic last_bit = 1'b1;
  exp_t q[$];

  always #5 clk = ~clk;

  assign line_i = !(line_pull_o || slave_hold);

  onewire_slot_engine #(.DIV_W(DIV_W)) i_onewire_slot_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .ovd_i(ovd_i),
    .reset_req_i(reset_req_i), .dat_i(dat_i),
    .ratio_norm_i(ratio_norm_i), .ratio_ovd_i(ratio_ovd_i),
    .line_i(line_i), .line_pull_o(line_pull_o),
    .busy_o(busy_o), .done_o(done_o), .bit_o(bit_o)
  );

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Driver: launches a cycle and pushes the expected outcome.
  task automatic issue(input logic o, input logic rs, input logic d,
                       input logic hold, input bit push, input string tag);
    exp_t e;
    int len, low, r;
    logic b;
    r = o ? int'(ratio_ovd_i) : int'(ratio_norm_i);
    case ({o, rs, d})
      3'b000: begin len = 9;   low = 8;  end
      3'b001: begin len = 9;   low = 1;  end
      3'b010: begin len = 128; low = 64; end
      3'b011: begin len = 128; low = 0;  end
      3'b100: begin len = 8;   low = 6;  end
      3'b101: begin len = 8;   low = 1;  end
      3'b110: begin len = 96;  low = 48; end
      default: begin len = 0;  low = 0;  end
    endcase
    if (rs && d)        b = last_bit;
    else if (!rs && !d) b = 1'b0;
    else                b = hold ? 1'b0 : 1'b1;
    @(posedge clk); #1;
    ovd_i = o; reset_req_i = rs; dat_i = d; slave_hold = hold; start_i = 1'b1;
    if (push) begin
      e.busy_clk = len * (r + 1);
      e.low_clk  = low * (r + 1);
      e.b        = b;
      e.tag      = tag;
      q.push_back(e);
      pushed++;
      last_bit = b;
    end
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_all();
    while (popped != pushed) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // Monitor: measures each cycle and compares at its done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (start_i) begin
        cnt_busy = 0;
        cnt_low  = 0;
      end else begin
        if (busy_o)      cnt_busy++;
        if (line_pull_o) cnt_low++;
        if (done_o) begin
          if (q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10: actual unexpected done expected none");
          end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " busy clocks R11"}, cnt_busy, e.busy_clk);
            check({e.tag, " low clocks"}, cnt_low, e.low_clk);
            check({e.tag, " bit R9"}, int'(bit_o), int'(e.b));
            popped++;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 pull", int'(line_pull_o), 0);
    check("R1 bit", int'(bit_o), 1);

    issue(0, 1, 0, 1, 1, "R3 reset present");      wait_all();
    issue(0, 1, 0, 0, 1, "R3 reset absent");       wait_all();
    issue(0, 0, 1, 0, 1, "R5 read one");           wait_all();
    issue(0, 0, 1, 1, 1, "R5 read zero");          wait_all();
    issue(0, 0, 0, 0, 1, "R4 write zero");         wait_all();
    issue(0, 0, 1, 0, 1, "R5 read one again");     wait_all();
    issue(0, 1, 1, 1, 1, "R8 idle normal");        wait_all();
    issue(1, 1, 0, 1, 1, "R6 ovd reset present");  wait_all();
    issue(1, 1, 0, 0, 1, "R6 ovd reset absent");   wait_all();
    issue(1, 0, 0, 0, 1, "R7 ovd write zero");     wait_all();
    issue(1, 0, 1, 0, 1, "R7 ovd read one");       wait_all();
    issue(1, 0, 1, 1, 1, "R7 ovd read zero");      wait_all();
    issue(1, 1, 1, 0, 1, "R8 idle ovd");           wait_all();

    issue(0, 0, 0, 0, 0, "R10 aborted");
    repeat (7) @(posedge clk);
    issue(0, 0, 1, 0, 1, "R10 restart read");      wait_all();
    issue(0, 1, 0, 1, 0, "R10 aborted reset");
    repeat (20) @(posedge clk);
    issue(1, 0, 1, 1, 1, "R10 restart ovd read");  wait_all();

    ratio_norm_i = 16'd5; ratio_ovd_i = 16'd4;
    issue(0, 0, 1, 1, 1, "R2 slow read zero");     wait_all();
    issue(1, 1, 0, 1, 1, "R2 slow ovd reset");     wait_all();
    issue(0, 1, 1, 0, 1, "R2 slow idle");          wait_all();

    check("R10 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule